// File: doc/BRIEF.md
# DTMF Period-Counting Tone Pair Decoder

This block decodes a dual-tone keypad signal that has already been split into its two frequency groups and hard-limited outside the block. It receives two square waves, one carrying the row tone and one carrying the column tone. Each square wave is resynchronised to the system clock, and the block counts reference ticks from one rising edge to the next.

Every measured period is compared against a window around each of the four nominal periods of its group. A group is declared to hold a tone only after a number of consecutive periods (`RUN_N`) all land in the window of the same nominal frequency. Small steady frequency errors are therefore accepted. Irregular signals such as speech, whose periods wander from one nominal to another, never collect a full run.

When both groups hold a tone, the early-steering output rises and the 4-bit key code is presented. The output falls again as soon as either group loses its tone. A group loses its tone when one period misses the window, when a period lands in another frequency's window, or when no edge arrives within a timeout. The timeout is derived from the group's slowest nominal frequency. Duration checking and latching of the code are left to the logic that follows.

Top module: `dtmf_period_decoder`

## Requirements
- R1: While reset is asserted, and after its release with no tones applied, `est_o` is 0 and `code_o` is 0000.
- R2: Square waves at the row frequencies 697, 770, 852 and 941 Hz, each at its nominal period in reference ticks (reference rate divided by frequency, rounded), are each recognised as a valid row tone.
- R3: Square waves at the column frequencies 1209, 1336, 1477 and 1633 Hz, each at its nominal period, are each recognised as a valid column tone.
- R4: With `est_o` high, `code_o` gives the key for the detected row and column. Keys 1 to 9 give 0001 to 1001, where rows 697/770/852 carry keys 1-3/4-6/7-9 and columns 1209/1336/1477 select the key within its row. Row 941 gives * = 1011 with 1209, 0 = 1010 with 1336 and # = 1100 with 1477. Column 1633 gives A = 1101, B = 1110, C = 1111 and D = 0000 with rows 697, 770, 852 and 941. The code does not change while `est_o` stays high.
- R5: `est_o` rises only while both groups hold a valid tone. A tone on one group alone never raises it.
- R6: A group's tone becomes valid only after `RUN_N` (default 4) consecutive periods all fall within the window of the same nominal frequency. A burst with fewer periods leaves `est_o` low.
- R7: The window spans the nominal period ±`TOL_PERMIL` per mille (default 25, truncated to whole ticks). Tones 2% off nominal are decoded, and tones 5% off nominal are rejected.
- R8: A group input whose consecutive periods alternate between two different nominal frequencies never becomes valid.
- R9: If a group sees no rising edge for its timeout, it drops its tone and `est_o` falls. The timeout is the nominal period of the group's slowest frequency times (100+`TOUT_PCT`)/100, with `TOUT_PCT` defaulting to 10.
- R10: A single period outside every window, seen while the pair is valid, makes `est_o` fall. `est_o` then stays low while such periods continue.
- R11: `code_o` is 0000 whenever `est_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_sq_i | input | 1 | Hard-limited row-group square wave, asynchronous to clk |
| high_sq_i | input | 1 | Hard-limited column-group square wave, asynchronous to clk |
| est_o | output | 1 | Early steering: high while a valid tone pair is present |
| code_o | output | 4 | Key code of the detected pair, 0000 while `est_o` is low |

## Verification
The bound checker watches several relations on every cycle:
- a rise of `est_o` always follows a group edge two cycles earlier;
- a fall always follows a run break, from a bad period or a timeout;
- the run counters never pass `RUN_N`, and both stand at `RUN_N` while steering is high;
- the code is steady while steering is high and zero while it is low.

Only the bench scenarios can show that each of the sixteen frequency pairs yields its own code and that the tolerance window sits where R7 puts it. They also show that alternating periods, single-group tones and short bursts never raise steering, and that the drop happens within the timeout bound.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

   localparam int GROUP_TONES = 4;
   localparam int CODE_W      = 4;

   typedef logic [1:0]        tone_idx_t;
   typedef logic [CODE_W-1:0] key_code_t;

   // Nominal tone frequency in Hz; grp 0 = row group, grp 1 = column group.
   function automatic int unsigned group_hz(input int grp, input int k);
      int unsigned f;
      if (grp == 0) begin
         case (k)
            0:       f = 697;
            1:       f = 770;
            2:       f = 852;
            default: f = 941;
         endcase
      end else begin
         case (k)
            0:       f = 1209;
            1:       f = 1336;
            2:       f = 1477;
            default: f = 1633;
         endcase
      end
      return f;
   endfunction

   // Nominal period in reference ticks, rounded to nearest.
   function automatic int unsigned nom_ticks(input int unsigned ref_hz, input int unsigned f);
      return (ref_hz + f / 2) / f;
   endfunction

   function automatic int unsigned win_low(input int unsigned ref_hz, input int unsigned f,
                                           input int unsigned tol_pm);
      return (nom_ticks(ref_hz, f) * (1000 - tol_pm)) / 1000;
   endfunction

   function automatic int unsigned win_high(input int unsigned ref_hz, input int unsigned f,
                                            input int unsigned tol_pm);
      return (nom_ticks(ref_hz, f) * (1000 + tol_pm)) / 1000;
   endfunction

   // Silence limit: slowest nominal period of the group plus a percentage.
   function automatic int unsigned silence_ticks(input int unsigned ref_hz, input int grp,
                                                 input int unsigned pct);
      return (nom_ticks(ref_hz, group_hz(grp, 0)) * (100 + pct)) / 100;
   endfunction

   // Row/column pair to 4-bit key code.
   function automatic key_code_t pair_code(input tone_idx_t row, input tone_idx_t col);
      key_code_t c;
      if (col == 2'd3) begin
         c = key_code_t'(4'd13 + {2'b00, row});
      end else if (row != 2'd3) begin
         c = key_code_t'({row, 1'b0} + row + {2'b00, col} + 4'd1);
      end else begin
         case (col)
            2'd0:    c = 4'd11;
            2'd1:    c = 4'd10;
            default: c = 4'd12;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/dtmf_ref_tick.sv
module dtmf_ref_tick #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (DIV == 1) begin : g_every
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_o <= 1'b0;
            else        tick_o <= 1'b1;
         end
      end else begin : g_divided
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q  <= '0;
               tick_o <= 1'b0;
            end else if (div_q == DW'(DIV - 1)) begin
               div_q  <= '0;
               tick_o <= 1'b1;
            end else begin
               div_q  <= div_q + 1'b1;
               tick_o <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dtmf_sync.sv
module dtmf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dtmf_group_tracker.sv
module dtmf_group_tracker
   import dtmf_pkg::*;
#(
   parameter int unsigned REF_HZ     = 1_000_000,
   parameter int          GROUP      = 0,
   parameter int          RUN_N      = 4,
   parameter int          RUN_W      = 3,
   parameter int unsigned TOL_PERMIL = 25,
   parameter int unsigned TOUT_PCT   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             sq_i,
   output logic             valid_o,
   output tone_idx_t        idx_o,
   output logic             edge_o,
   output logic             brk_o,
   output logic [RUN_W-1:0] run_o
);

   localparam int unsigned TOUT  = silence_ticks(REF_HZ, GROUP, TOUT_PCT);
   localparam int          CNT_W = $clog2(TOUT + 1);

   logic             sq_q;
   logic [CNT_W-1:0] cnt_q;
   logic             started_q;
   logic [RUN_W-1:0] run_q;
   tone_idx_t        idx_q;
   logic             valid_q;

   logic [GROUP_TONES-1:0] hit;
   logic                   hit_any;
   tone_idx_t              hit_idx;
   logic                   edge_w;
   logic                   quiet_w;
   logic                   extend_w;
   logic [RUN_W:0]         run_next;

   assign edge_w  = sq_i & ~sq_q;
   assign quiet_w = (cnt_q == CNT_W'(TOUT));

   // One window comparator per nominal frequency of the group.
   generate
      for (genvar k = 0; k < GROUP_TONES; k++) begin : g_win
         localparam int unsigned LO_B = win_low(REF_HZ, group_hz(GROUP, k), TOL_PERMIL);
         localparam int unsigned HI_B = win_high(REF_HZ, group_hz(GROUP, k), TOL_PERMIL);
         assign hit[k] = (cnt_q >= CNT_W'(LO_B)) && (cnt_q <= CNT_W'(HI_B));
      end
   endgenerate

   always_comb begin
      hit_idx = '0;
      for (int k = 0; k < GROUP_TONES; k++) begin
         if (hit[k]) hit_idx = tone_idx_t'(k);
      end
   end

   assign hit_any  = |hit;
   assign extend_w = hit_any && (hit_idx == idx_q) && (run_q != '0);
   assign run_next = {1'b0, run_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q      <= 1'b0;
         cnt_q     <= '0;
         started_q <= 1'b0;
         run_q     <= '0;
         idx_q     <= '0;
         valid_q   <= 1'b0;
      end else begin
         sq_q <= sq_i;
         if (edge_w) begin
            cnt_q <= tick_i ? CNT_W'(1) : '0;
            if (!started_q) begin
               started_q <= 1'b1;
            end else if (extend_w) begin
               if (run_q != RUN_W'(RUN_N)) run_q <= run_next[RUN_W-1:0];
               valid_q <= (run_next >= (RUN_W + 1)'(RUN_N));
            end else if (hit_any) begin
               idx_q   <= hit_idx;
               run_q   <= RUN_W'(1);
               valid_q <= 1'b0;
            end else begin
               run_q   <= '0;
               valid_q <= 1'b0;
            end
         end else begin
            if (tick_i && !quiet_w) cnt_q <= cnt_q + 1'b1;
            if (started_q && quiet_w) begin
               started_q <= 1'b0;
               run_q     <= '0;
               valid_q   <= 1'b0;
            end
         end
      end
   end

   assign valid_o = valid_q;
   assign idx_o   = idx_q;
   assign edge_o  = edge_w;
   assign brk_o   = started_q && ((edge_w && !extend_w) || (!edge_w && quiet_w));
   assign run_o   = run_q;

endmodule

// File: rtl/dtmf_period_decoder.sv
module dtmf_period_decoder
   import dtmf_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int          REF_DIV     = 50,
   parameter int          RUN_N       = 4,
   parameter int unsigned TOL_PERMIL  = 25,
   parameter int unsigned TOUT_PCT    = 10,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       low_sq_i,
   input  logic       high_sq_i,
   output logic       est_o,
   output logic [3:0] code_o
);

   localparam int unsigned REF_HZ = CLK_HZ / REF_DIV;
   localparam int          RUN_W  = $clog2(RUN_N + 1);
   localparam int          NGRP   = 2;

   generate
      if (REF_DIV < 1)                   begin : g_bad_div  $error("REF_DIV must be at least 1");            end
      if (RUN_N < 2)                     begin : g_bad_run  $error("RUN_N must be at least 2");              end
      if (TOL_PERMIL >= 45)              begin : g_bad_tol  $error("TOL_PERMIL lets adjacent windows meet"); end
      if (TOUT_PCT * 10 <= TOL_PERMIL)   begin : g_bad_tout $error("TOUT_PCT must exceed the tolerance");    end
      if (SYNC_STAGES < 1)               begin : g_bad_sync $error("SYNC_STAGES must be at least 1");        end
      if (REF_HZ / 1633 < 20)            begin : g_bad_ref  $error("reference rate too low to resolve tones"); end
   endgenerate

   logic                       tick;
   logic [NGRP-1:0]            sq_raw;
   logic [NGRP-1:0]            sq_sync;
   logic [NGRP-1:0]            grp_valid;
   logic [NGRP-1:0]            grp_edge;
   logic [NGRP-1:0]            grp_brk;
   logic [NGRP-1:0][RUN_W-1:0] grp_run;
   tone_idx_t                  grp_idx [NGRP];
   key_code_t                  pair_w;
   logic                       est_q;
   key_code_t                  code_q;

   assign sq_raw = {high_sq_i, low_sq_i};

   dtmf_ref_tick #(.DIV(REF_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         dtmf_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (sq_raw[g]),
            .q_o   (sq_sync[g])
         );

         dtmf_group_tracker #(
            .REF_HZ     (REF_HZ),
            .GROUP      (g),
            .RUN_N      (RUN_N),
            .RUN_W      (RUN_W),
            .TOL_PERMIL (TOL_PERMIL),
            .TOUT_PCT   (TOUT_PCT)
         ) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .sq_i    (sq_sync[g]),
            .valid_o (grp_valid[g]),
            .idx_o   (grp_idx[g]),
            .edge_o  (grp_edge[g]),
            .brk_o   (grp_brk[g]),
            .run_o   (grp_run[g])
         );
      end
   endgenerate

   assign pair_w = pair_code(grp_idx[0], grp_idx[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_q  <= 1'b0;
         code_q <= '0;
      end else begin
         est_q  <= &grp_valid;
         code_q <= (&grp_valid) ? pair_w : '0;
      end
   end

   assign est_o  = est_q;
   assign code_o = code_q;

endmodule

// File: rtl/dtmf_period_decoder_chk.sv
module dtmf_period_decoder_chk #(
   parameter int RUN_N = 4,
   parameter int RUN_W = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  est,
   input logic [3:0]            code,
   input logic [1:0]            grp_edge,
   input logic [1:0]            grp_brk,
   input logic [1:0][RUN_W-1:0] grp_run
);

   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !est |-> (code == 4'd0));                                                      // R11

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (est && $past(est)) |-> $stable(code));                                        // R4

   AST_RISE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(est) |-> $past(|grp_edge, 2));                                           // R5

   AST_FALL_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(est) |-> $past(|grp_brk, 2));                                            // R10

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_run[0] <= RUN_W'(RUN_N)) && (grp_run[1] <= RUN_W'(RUN_N)));               // R6

   AST_EST_FULL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      est |-> $past((grp_run[0] == RUN_W'(RUN_N)) && (grp_run[1] == RUN_W'(RUN_N)))); // R6

endmodule

bind dtmf_period_decoder dtmf_period_decoder_chk #(
   .RUN_N (RUN_N),
   .RUN_W (RUN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .est      (est_o),
   .code     (code_o),
   .grp_edge (grp_edge),
   .grp_brk  (grp_brk),
   .grp_run  (grp_run)
);

// File: tb/dtmf_period_decoder_tb_top.sv
module dtmf_period_decoder_tb_top;

   localparam int CLK_HZ = 200_000;   // scaled reference: one tick per clock
   localparam int RUN_N  = 4;
   localparam int LO_P [4] = '{287, 260, 235, 213};
   localparam int HI_P [4] = '{165, 150, 135, 122};
   localparam logic [3:0] KEYS [4][4] = '{'{4'd1, 4'd2,  4'd3,  4'd13},
                                         '{4'd4, 4'd5,  4'd6,  4'd14},
                                         '{4'd7, 4'd8,  4'd9,  4'd15},
                                         '{4'd11, 4'd10, 4'd12, 4'd0}};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       low_sq = 1'b0;
   logic       high_sq = 1'b0;
   logic       est;
   logic [3:0] code;

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   int    lo_per = 0;
   int    lo_alt = 0;
   int    hi_per = 0;
   int    rise_cyc = -1;
   string cur_req = "R1";
   logic [3:0] exp_q [$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dtmf_period_decoder #(
      .CLK_HZ      (CLK_HZ),
      .REF_DIV     (1),
      .RUN_N       (RUN_N),
      .TOL_PERMIL  (25),
      .TOUT_PCT    (10),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .low_sq_i  (low_sq),
      .high_sq_i (high_sq),
      .est_o     (est),
      .code_o    (code)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // Row-group tone source; a nonzero lo_alt alternates the period.
   initial begin
      bit ph = 1'b0;
      forever begin
         int p;
         @(negedge clk);
         if (lo_per == 0) begin
            low_sq = 1'b0;
         end else begin
            p = (lo_alt != 0 && ph) ? lo_alt : lo_per;
            ph = ~ph;
            low_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            low_sq = 1'b0;
            repeat (p - p / 2 - 1) @(negedge clk);
         end
      end
   end

   // Column-group tone source.
   initial begin
      forever begin
         int p;
         @(negedge clk);
         if (hi_per == 0) begin
            high_sq = 1'b0;
         end else begin
            p = hi_per;
            high_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            high_sq = 1'b0;
            repeat (p - p / 2 - 1) @(negedge clk);
         end
      end
   end

   // Monitor: each steering rise pops one expected code.
   initial begin
      logic prev = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && est && !prev) begin
            rise_cyc = cyc;
            if (exp_q.size() == 0) begin
               check(1'b0, cur_req, "unexpected steering rise", 1, 0);
            end else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               check(code == e, "R4", "code at steering rise", code, e);
            end
         end
         prev = est;
      end
   end

   task automatic stop_all();
      lo_per = 0;
      lo_alt = 0;
      hi_per = 0;
      repeat (700) @(negedge clk);
   endtask

   task automatic play_pair(input int lp, input int hp, input logic [3:0] e, input string req);
      int t0;
      cur_req = req;
      exp_q.push_back(e);
      rise_cyc = -1;
      t0 = cyc;
      lo_per = lp;
      hi_per = hp;
      repeat ((RUN_N + 2) * lp + 20) @(negedge clk);
      check(exp_q.size() == 0, req, "steering rose for pair", exp_q.size(), 0);
      exp_q.delete();
      check(rise_cyc - t0 >= RUN_N * lp, "R6", "rise no earlier than N periods",
            rise_cyc - t0, RUN_N * lp);
      check(est == 1'b1, req, "steering held during pair", est, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(est == 1'b0, "R1", "est during reset", est, 0);
      check(code == 4'd0, "R1", "code during reset", code, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(est == 1'b0, "R1", "est after reset", est, 0);
      check(code == 4'd0, "R11", "code idle after reset", code, 0);

      // All sixteen pairs: R2 rows, R3 columns, R4 codes, R9 silence drop.
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            play_pair(LO_P[r], HI_P[c], KEYS[r][c], (c == 0) ? "R2" : "R3");
            cur_req = "R9";
            stop_all();
            check(est == 1'b0, "R9", "steering dropped after silence", est, 0);
            check(code == 4'd0, "R11", "code zero after drop", code, 0);
         end
      end

      // R7: 2% fast tones accepted (770->255, 1336->147), key 5.
      play_pair(255, 147, 4'd5, "R7");
      stop_all();

      // R7: 5% fast row tone rejected.
      cur_req = "R7";
      lo_per = 248;
      hi_per = 150;
      repeat (2500) @(negedge clk);
      check(est == 1'b0, "R7", "5% off row tone rejected", est, 0);
      stop_all();

      // R8: row periods alternate between 697 and 770 nominal.
      cur_req = "R8";
      lo_per = 287;
      lo_alt = 260;
      hi_per = 150;
      repeat (3000) @(negedge clk);
      check(est == 1'b0, "R8", "alternating periods rejected", est, 0);
      stop_all();

      // R5: one group alone.
      cur_req = "R5";
      lo_per = 287;
      repeat (3000) @(negedge clk);
      check(est == 1'b0, "R5", "row tone alone", est, 0);
      stop_all();
      hi_per = 135;
      repeat (3000) @(negedge clk);
      check(est == 1'b0, "R5", "column tone alone", est, 0);
      stop_all();

      // R6: burst of fewer than N row periods.
      cur_req = "R6";
      lo_per = 287;
      hi_per = 165;
      repeat (3 * 287 - 50) @(negedge clk);
      lo_per = 0;
      hi_per = 0;
      repeat (1500) @(negedge clk);
      check(est == 1'b0, "R6", "short burst gives no steering", est, 0);

      // R9: column tone alone goes silent while the pair is valid.
      play_pair(LO_P[0], HI_P[0], KEYS[0][0], "R9");
      cur_req = "R9";
      hi_per = 0;
      repeat (400) @(negedge clk);
      check(est == 1'b0, "R9", "drop after column silence", est, 0);
      stop_all();

      // R10: row period moves outside every window while the pair is valid.
      play_pair(LO_P[1], HI_P[1], KEYS[1][1], "R10");
      cur_req = "R10";
      lo_per = 301;
      repeat (620) @(negedge clk);
      check(est == 1'b0, "R10", "drop after out-of-window period", est, 0);
      check(code == 4'd0, "R11", "code zero after bad period", code, 0);
      repeat (1500) @(negedge clk);
      check(est == 1'b0, "R10", "stays low with bad periods", est, 0);
      stop_all();

      check(exp_q.size() == 0, "R4", "no pending expected codes", exp_q.size(), 0);
      summary();
      $finish;
   end

   initial begin
      repeat (190_000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog %s run hung act=%0d exp=%0d", cur_req, cyc, 190_000);
      summary();
      $finish;
   end

endmodule